// File: doc/BRIEF.md
# Receive/Transmit Interrupt Delay Unit

This block sits between the receive and transmit engines and the interrupt cause register. It decides which causes the host sees straight away and which it holds back. A cause that can be delayed is parked in a pending register. When the first timer runs out, or when something arrives that cannot wait, everything parked is released together. The result is fewer host interrupts under steady traffic, while the wait stays bounded.

Five down-counters share one prescaler tick. Three serve the receive side: a packet timer, an absolute timer and an ACK timer. Two serve the transmit side: a packet timer and an absolute timer. A packet timer is reloaded on every event it holds back, so it measures quiet time. An absolute timer is loaded only once per hold-back window, so it caps the total wait. The output is a one-cycle fire strobe together with the cause bits to be ORed into the cause register. When per-vector interrupt mode is selected, the unit passes every cause straight through.

Top module: `irq_delay_unit`

## Requirements
- R1: After reset, `irq_fire` is 0, `irq_cause` is all zero, nothing is pending and no timer runs.
- R2: On the receive side, the causes that can be delayed are queue-0 receive (bit 20), queue-1 receive (bit 21) and receive timer (bit 7). ACK received (bit 17) can also be delayed while `cfg_ack_nodelay` is 0. While `cfg_ack_nodelay` is 1, bit 17 counts as a cause that cannot be delayed.
- R3: On the transmit side, the causes that can be delayed are queue-0 transmit (bit 22), queue-1 transmit (bit 23), queue empty (bit 1) and descriptor written back (bit 0). All other bits cannot be delayed.
- R4: While `cfg_vec_mode` is 1, no cause is held. Each event is signalled unchanged on the next cycle, together with anything already pending.
- R5: If an event carries any cause that cannot be delayed, everything is signalled on the next cycle: the causes that cannot wait, the delayable causes of the same event and all pending causes. The pending register is then cleared and every timer is stopped.
- R6: A receive event is signalled at once, not held, when `cfg_rx_pkt_dly` is 0.
- R7: When `cfg_ack_dly` is 0, a receive event that would leave an ACK cause pending is signalled at once, together with all pending causes.
- R8: Each held event reloads its direction's packet timer with the configured value, even if that timer is already running. A timer loaded with N expires on the N-th prescaler tick after the load.
- R9: An absolute timer is loaded on a held event only when it is idle and its configured value is nonzero. Later held events do not restart it.
- R10: The ACK timer is loaded on a held receive event only when it is idle and an ACK cause is pending.
- R11: When any timer expires, all pending causes are output with a one-cycle `irq_fire`, the pending register is cleared and all five timers stop.
- R12: A transmit event is held only when `tx_delay_req` is 1, `cfg_vec_mode` is 0, all its causes can be delayed and `cfg_tx_pkt_dly` is nonzero. Otherwise it is signalled on the next cycle.
- R13: The prescaler tick occurs once every `TICK_DIV` clock cycles, starting with the `TICK_DIV`-th cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A receive cause event is present this cycle |
| rx_cause | input | CAUSE_W | Receive cause bits |
| tx_valid | input | 1 | A transmit cause event is present this cycle |
| tx_cause | input | CAUSE_W | Transmit cause bits |
| tx_delay_req | input | 1 | The triggering descriptor asked for a delayed interrupt |
| cfg_vec_mode | input | 1 | Per-vector interrupt mode; bypasses all delay |
| cfg_ack_nodelay | input | 1 | Makes the ACK cause one that cannot be delayed |
| cfg_rx_pkt_dly | input | DLY_W | Receive packet timer reload, in ticks |
| cfg_rx_abs_dly | input | DLY_W | Receive absolute timer reload, in ticks |
| cfg_ack_dly | input | DLY_W | ACK timer reload, in ticks |
| cfg_tx_pkt_dly | input | DLY_W | Transmit packet timer reload, in ticks |
| cfg_tx_abs_dly | input | DLY_W | Transmit absolute timer reload, in ticks |
| irq_fire | output | 1 | One-cycle strobe: `irq_cause` is to be ORed in |
| irq_cause | output | CAUSE_W | Released cause bits, zero when not firing |

## Verification
An event that is signalled at once shows up on `irq_fire` and `irq_cause` exactly one cycle after the clock edge that samples it. An expiry shows up one cycle after the edge on which a timer holding 1 sees a tick. The bench keeps a behavioural model that applies the same inputs at each rising edge and predicts the registered outputs for the following cycle. It compares them at the falling edge of every cycle, so a result that comes one cycle early or late is reported. Tick phase is counted from reset release in the model, so the expiry cycle of each timer is predicted exactly.

// File: rtl/irq_delay_pkg.sv
package irq_delay_pkg;
   // Cause bit positions shared with the interrupt cause register.
   localparam int B_TX_WB    = 0;
   localparam int B_TX_EMPTY = 1;
   localparam int B_RX_TMR   = 7;
   localparam int B_ACK      = 17;
   localparam int B_RXQ0     = 20;
   localparam int B_RXQ1     = 21;
   localparam int B_TXQ0     = 22;
   localparam int B_TXQ1     = 23;
   localparam int CAUSE_MIN_W = 24;

   // Timer slots.
   localparam int NUM_TMR  = 5;
   localparam int T_RX_PKT = 0;
   localparam int T_RX_ABS = 1;
   localparam int T_ACK    = 2;
   localparam int T_TX_PKT = 3;
   localparam int T_TX_ABS = 4;
endpackage

// File: rtl/idu_prescaler.sv
module idu_prescaler #(
   parameter int DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("idu_prescaler: DIV must be at least 1");
      end else if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);

         // R13: ticks never come back to back when the divider exceeds one
         a_r13_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/idu_timer.sv
module idu_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         stop,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         running,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (stop)                cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign running = (cnt_q != '0);
   assign expire  = tick && (cnt_q == W'(1));

   // R8: a load that is not overridden by a stop takes the configured value
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !stop) |=> (cnt_q == $past(load_val)));
   // R11: a stop leaves the timer idle
   a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !running);
endmodule

// File: rtl/idu_path.sv
module idu_path #(
   parameter int CW = 32
) (
   input  logic          valid,
   input  logic [CW-1:0] cause,
   input  logic [CW-1:0] mask,
   input  logic          bypass,
   input  logic          allow,
   output logic [CW-1:0] delayed,
   output logic [CW-1:0] rest,
   output logic          hold
);
   logic [CW-1:0] eff_mask;

   always_comb begin
      eff_mask = bypass ? '0 : mask;
      delayed  = valid ? (cause & eff_mask)  : '0;
      rest     = valid ? (cause & ~eff_mask) : '0;
      hold     = valid && !bypass && allow && (rest == '0);
   end
endmodule

// File: rtl/irq_delay_unit.sv
module irq_delay_unit
   import irq_delay_pkg::*;
#(
   parameter int CAUSE_W  = 32,
   parameter int DLY_W    = 16,
   parameter int TICK_DIV = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [CAUSE_W-1:0] rx_cause,
   input  logic               tx_valid,
   input  logic [CAUSE_W-1:0] tx_cause,
   input  logic               tx_delay_req,
   input  logic               cfg_vec_mode,
   input  logic               cfg_ack_nodelay,
   input  logic [DLY_W-1:0]   cfg_rx_pkt_dly,
   input  logic [DLY_W-1:0]   cfg_rx_abs_dly,
   input  logic [DLY_W-1:0]   cfg_ack_dly,
   input  logic [DLY_W-1:0]   cfg_tx_pkt_dly,
   input  logic [DLY_W-1:0]   cfg_tx_abs_dly,
   output logic               irq_fire,
   output logic [CAUSE_W-1:0] irq_cause
);
   localparam logic [CAUSE_W-1:0] ONE     = CAUSE_W'(1);
   localparam logic [CAUSE_W-1:0] ACK_BIT = ONE << B_ACK;
   localparam logic [CAUSE_W-1:0] RX_BASE = (ONE << B_RXQ0) | (ONE << B_RXQ1) | (ONE << B_RX_TMR);
   localparam logic [CAUSE_W-1:0] TX_MASK = (ONE << B_TXQ0) | (ONE << B_TXQ1)
                                          | (ONE << B_TX_EMPTY) | (ONE << B_TX_WB);
   localparam logic [CAUSE_W-1:0] ALL_DLY = RX_BASE | ACK_BIT | TX_MASK;

   generate
      if (CAUSE_W < CAUSE_MIN_W) begin : g_bad_cw
         $error("irq_delay_unit: CAUSE_W too narrow for the cause map");
      end
      if (DLY_W < 1) begin : g_bad_dw
         $error("irq_delay_unit: DLY_W must be positive");
      end
   endgenerate

   logic               tick;
   logic [CAUSE_W-1:0] pend_q, pend_nx, rx_mask;
   logic [CAUSE_W-1:0] rx_del, rx_rest, tx_del, tx_rest;
   logic               rx_hold_p, tx_hold_p, rx_hold, tx_hold, ack_blk;
   logic               rx_now, tx_now, any_exp, flush;
   logic [NUM_TMR-1:0] t_load, t_run, t_exp;
   logic [DLY_W-1:0]   t_val [NUM_TMR];

   idu_prescaler #(.DIV(TICK_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   assign rx_mask = RX_BASE | (cfg_ack_nodelay ? '0 : ACK_BIT);

   idu_path #(.CW(CAUSE_W)) u_rx_path (
      .valid(rx_valid), .cause(rx_cause), .mask(rx_mask), .bypass(cfg_vec_mode),
      .allow(cfg_rx_pkt_dly != '0),
      .delayed(rx_del), .rest(rx_rest), .hold(rx_hold_p)
   );

   idu_path #(.CW(CAUSE_W)) u_tx_path (
      .valid(tx_valid), .cause(tx_cause), .mask(TX_MASK), .bypass(cfg_vec_mode),
      .allow(tx_delay_req && (cfg_tx_pkt_dly != '0)),
      .delayed(tx_del), .rest(tx_rest), .hold(tx_hold_p)
   );

   always_comb begin
      pend_nx = pend_q | rx_del | tx_del;
      ack_blk = (cfg_ack_dly == '0) && pend_nx[B_ACK];
      rx_hold = rx_hold_p && !ack_blk;
      tx_hold = tx_hold_p;
      rx_now  = rx_valid && !rx_hold;
      tx_now  = tx_valid && !tx_hold;
      any_exp = |t_exp;
      flush   = any_exp || rx_now || tx_now;
   end

   always_comb begin
      t_load[T_RX_PKT] = rx_hold;
      t_load[T_RX_ABS] = rx_hold && !t_run[T_RX_ABS] && (cfg_rx_abs_dly != '0);
      t_load[T_ACK]    = rx_hold && !t_run[T_ACK] && pend_nx[B_ACK];
      t_load[T_TX_PKT] = tx_hold;
      t_load[T_TX_ABS] = tx_hold && !t_run[T_TX_ABS] && (cfg_tx_abs_dly != '0);
      t_val[T_RX_PKT]  = cfg_rx_pkt_dly;
      t_val[T_RX_ABS]  = cfg_rx_abs_dly;
      t_val[T_ACK]     = cfg_ack_dly;
      t_val[T_TX_PKT]  = cfg_tx_pkt_dly;
      t_val[T_TX_ABS]  = cfg_tx_abs_dly;
   end

   for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      idu_timer #(.W(DLY_W)) u_tmr (
         .clk(clk), .rst_n(rst_n), .tick(tick), .stop(flush),
         .load(t_load[gi]), .load_val(t_val[gi]),
         .running(t_run[gi]), .expire(t_exp[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         irq_fire  <= 1'b0;
         irq_cause <= '0;
      end else begin
         pend_q    <= flush ? '0 : pend_nx;
         irq_fire  <= flush;
         irq_cause <= flush ? (rx_rest | tx_rest | pend_nx) : '0;
      end
   end

   // R3: only delayable causes can ever sit in the pending register
   a_r3_pend_delayable: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~ALL_DLY) == '0);
   // R11: whenever a flush is visible, nothing is pending and no timer runs
   a_r11_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fire |-> (pend_q == '0 && t_run == '0));
   // R4: per-vector mode never holds an event
   a_r4_vec_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_vec_mode && (rx_valid || tx_valid)) |=> irq_fire);
   // R6: a zero receive packet delay never holds a receive event
   a_r6_rx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_rx_pkt_dly == '0) |=> irq_fire);
   // R12: a transmit event without a delay request is signalled at once
   a_r12_tx_noreq: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_delay_req) |=> irq_fire);
endmodule

// File: tb/tb_irq_delay_unit.sv
`timescale 1ns/1ps
module tb_irq_delay_unit;
   localparam int CW  = 32;
   localparam int DW  = 16;
   localparam int DIV = 4;

   localparam logic [CW-1:0] ACKB  = 32'h1 << 17;
   localparam logic [CW-1:0] RXB   = (32'h1 << 20) | (32'h1 << 21) | (32'h1 << 7);
   localparam logic [CW-1:0] TXB   = (32'h1 << 22) | (32'h1 << 23) | 32'h3;
   localparam logic [CW-1:0] OTHER = 32'h1 << 3;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          rx_valid = 0, tx_valid = 0, tx_delay_req = 0;
   logic [CW-1:0] rx_cause = '0, tx_cause = '0;
   logic          cfg_vec_mode = 0, cfg_ack_nodelay = 0;
   logic [DW-1:0] cfg_rx_pkt_dly = 0, cfg_rx_abs_dly = 0, cfg_ack_dly = 0;
   logic [DW-1:0] cfg_tx_pkt_dly = 0, cfg_tx_abs_dly = 0;
   logic          irq_fire;
   logic [CW-1:0] irq_cause;

   int    n_checks = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";
   bit    done = 0;

   always #2 clk = ~clk;

   irq_delay_unit #(.CAUSE_W(CW), .DLY_W(DW), .TICK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_cause(rx_cause),
      .tx_valid(tx_valid), .tx_cause(tx_cause), .tx_delay_req(tx_delay_req),
      .cfg_vec_mode(cfg_vec_mode), .cfg_ack_nodelay(cfg_ack_nodelay),
      .cfg_rx_pkt_dly(cfg_rx_pkt_dly), .cfg_rx_abs_dly(cfg_rx_abs_dly),
      .cfg_ack_dly(cfg_ack_dly), .cfg_tx_pkt_dly(cfg_tx_pkt_dly),
      .cfg_tx_abs_dly(cfg_tx_abs_dly),
      .irq_fire(irq_fire), .irq_cause(irq_cause)
   );

   // Behavioural reference: pending word, five tick counters, prescaler phase.
   logic [CW-1:0] m_pend, m_cause;
   logic          m_fire;
   int            m_tm [5];
   int            m_pc;

   always @(posedge clk) begin
      logic          tk, ex, now, rxh, txh, l1, l2, l4;
      logic [CW-1:0] pn, rest, rxm;
      if (!rst_n) begin
         m_pend = '0; m_cause = '0; m_fire = 0; m_pc = 0;
         for (int t = 0; t < 5; t++) m_tm[t] = 0;
      end else begin
         tk = (m_pc == DIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         ex = 0;
         for (int t = 0; t < 5; t++) if (tk && m_tm[t] == 1) ex = 1;
         rxm = RXB | (cfg_ack_nodelay ? '0 : ACKB);
         pn = m_pend; rest = '0; now = 0; rxh = 0; txh = 0;
         if (rx_valid) begin
            if (cfg_vec_mode) begin rest |= rx_cause; now = 1; end
            else begin
               pn |= rx_cause & rxm;
               if ((rx_cause & ~rxm) != 0) begin rest |= rx_cause & ~rxm; now = 1; end
               else if (cfg_rx_pkt_dly == 0) now = 1;
               else rxh = 1;
            end
         end
         if (tx_valid) begin
            if (cfg_vec_mode) begin rest |= tx_cause; now = 1; end
            else begin
               pn |= tx_cause & TXB;
               if ((tx_cause & ~TXB) != 0) begin rest |= tx_cause & ~TXB; now = 1; end
               else if (!tx_delay_req || cfg_tx_pkt_dly == 0) now = 1;
               else txh = 1;
            end
         end
         if (rxh && cfg_ack_dly == 0 && (pn & ACKB) != 0) begin rxh = 0; now = 1; end
         if (ex || now) begin
            m_fire = 1; m_cause = rest | pn; m_pend = '0;
            for (int t = 0; t < 5; t++) m_tm[t] = 0;
         end else begin
            m_fire = 0; m_cause = '0; m_pend = pn;
            l1 = rxh && m_tm[1] == 0 && cfg_rx_abs_dly != 0;
            l2 = rxh && m_tm[2] == 0 && (pn & ACKB) != 0;
            l4 = txh && m_tm[4] == 0 && cfg_tx_abs_dly != 0;
            for (int t = 0; t < 5; t++) if (tk && m_tm[t] > 0) m_tm[t]--;
            if (rxh) m_tm[0] = cfg_rx_pkt_dly;
            if (l1)  m_tm[1] = cfg_rx_abs_dly;
            if (l2)  m_tm[2] = cfg_ack_dly;
            if (txh) m_tm[3] = cfg_tx_pkt_dly;
            if (l4)  m_tm[4] = cfg_tx_abs_dly;
         end
      end
   end

   // Compare away from the active edge, every cycle.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (irq_fire !== m_fire || irq_cause !== m_cause) begin
            n_fail++;
            $display("FAIL %s cyc %0d: fire=%b cause=%h expected fire=%b cause=%h",
                     cur_req, cyc, irq_fire, irq_cause, m_fire, m_cause);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rx_ev(input logic [CW-1:0] c);
      @(negedge clk); rx_valid = 1; rx_cause = c;
      @(negedge clk); rx_valid = 0; rx_cause = '0;
   endtask

   task automatic tx_ev(input logic [CW-1:0] c, input logic req);
      @(negedge clk); tx_valid = 1; tx_cause = c; tx_delay_req = req;
      @(negedge clk); tx_valid = 0; tx_cause = '0; tx_delay_req = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state seen at the ports
      @(negedge clk);
      n_checks++;
      if (irq_fire !== 1'b0 || irq_cause !== '0) begin
         n_fail++;
         $display("FAIL R1: fire=%b cause=%h expected fire=0 cause=0", irq_fire, irq_cause);
      end
      idle(6);

      cur_req = "R4";
      cfg_vec_mode = 1; cfg_rx_pkt_dly = 5;
      rx_ev(32'h1 << 20); idle(2);
      tx_ev(32'h1 << 22, 1); idle(3);
      cfg_vec_mode = 0;

      cur_req = "R6";
      cfg_rx_pkt_dly = 0;
      rx_ev(32'h1 << 21); idle(3);

      cur_req = "R8";
      cfg_rx_pkt_dly = 3; cfg_ack_dly = 4;
      rx_ev(32'h1 << 20); idle(4);
      rx_ev(32'h1 << 7);  idle(4);
      rx_ev(32'h1 << 21); idle(30);

      cur_req = "R9";
      cfg_rx_abs_dly = 5;
      for (int k = 0; k < 6; k++) begin rx_ev(32'h1 << 20); idle(5); end
      idle(30);
      cfg_rx_abs_dly = 0;

      cur_req = "R7";
      cfg_ack_dly = 0;
      rx_ev(32'h1 << 20); idle(2);
      rx_ev(ACKB); idle(4);

      cur_req = "R2";
      cfg_ack_dly = 4; cfg_ack_nodelay = 1;
      rx_ev(32'h1 << 21); idle(1);
      rx_ev(ACKB); idle(4);
      cfg_ack_nodelay = 0;

      cur_req = "R10";
      cfg_rx_pkt_dly = 12; cfg_ack_dly = 2;
      rx_ev(ACKB | (32'h1 << 20)); idle(4);
      rx_ev(ACKB); idle(30);

      cur_req = "R3";
      cfg_tx_pkt_dly = 3; cfg_tx_abs_dly = 0;
      tx_ev(32'h1 << 1, 1); idle(2);
      tx_ev((32'h1 << 23) | 32'h1, 1); idle(30);
      tx_ev(32'h1 << 0 | OTHER, 1); idle(4);

      cur_req = "R12";
      tx_ev(32'h1 << 22, 0); idle(3);
      cfg_tx_pkt_dly = 0;
      tx_ev(32'h1 << 22, 1); idle(3);
      cfg_tx_pkt_dly = 4; cfg_tx_abs_dly = 6;
      for (int k = 0; k < 6; k++) begin tx_ev(32'h1 << 22, 1); idle(6); end
      idle(40);

      cur_req = "R5";
      cfg_rx_pkt_dly = 20; cfg_ack_dly = 20;
      rx_ev(32'h1 << 20); idle(2);
      tx_ev(32'h1 << 23, 1); idle(2);
      rx_ev(OTHER); idle(4);

      cur_req = "R11";
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         rx_valid     = ($urandom % 4) == 0;
         rx_cause     = ($urandom & (RXB | ACKB)) | ((($urandom % 16) == 0) ? OTHER : '0);
         tx_valid     = ($urandom % 5) == 0;
         tx_cause     = ($urandom & TXB) | ((($urandom % 16) == 0) ? OTHER : '0);
         tx_delay_req = ($urandom % 4) != 0;
         if ((k % 100) == 0) begin
            cfg_rx_pkt_dly  = DW'($urandom % 5);
            cfg_rx_abs_dly  = DW'($urandom % 7);
            cfg_ack_dly     = DW'($urandom % 4);
            cfg_tx_pkt_dly  = DW'($urandom % 5);
            cfg_tx_abs_dly  = DW'($urandom % 7);
            cfg_ack_nodelay = ($urandom % 3) == 0;
            cfg_vec_mode    = ($urandom % 6) == 0;
         end
      end
      @(negedge clk);
      rx_valid = 0; tx_valid = 0;
      idle(40);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule